// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block picks one winner from a set of interrupt request lines. Requests that are masked are dropped first. The remaining lines are then ranked starting from a programmable rotation base: the line at the base has the best rank, the next line up has the next rank, and the ranking wraps around. The best-ranked pending line wins. A new interrupt is signalled only when that winner strictly outranks the best-ranked line that is already in service.

The in-service set can be adjusted in two ways before its level is measured:

- **Special mask mode:** masked lines are removed from the in-service set.
- **Special nesting mode:** on a unit that has the master role, the in-service bit of the cascade line is ignored.

The winning line and its valid flag are combinational. The interrupt output is a registered copy of the valid flag. Programming the controller's registers, running acknowledge cycles and cascading to other units are handled outside this block.

There is no sequencing here: the only state is the interrupt output flop. It has two values, low after reset and then following the valid flag.

Top module: `prio_resolver`

## Requirements
- R1: The pending set is `req_vec & ~mask_vec`. A masked request never wins, and a winning line always has its request bit set and its mask bit clear.
- R2: The line whose index is `(k + rot_base) mod 8` has rank k, and rank 0 is the best. The winner is the pending line with the smallest rank.
- R3: When the pending set is empty, `grant_valid` is 0.
- R4: The service rank is the smallest rank among the in-service bits, or 8 when none are set. `grant_valid` is 1 only when the winner's rank is strictly smaller than the service rank, so an equal rank blocks the grant.
- R5: When `spec_mask_en` is 1, in-service bits whose mask bit is 1 are cleared before the service rank is found. When `spec_mask_en` is 0, masked in-service bits still block.
- R6: When `spec_nest_en` and `is_master` are both 1, in-service bit 2 (the cascade line) is ignored. When either of them is 0, bit 2 counts like any other bit.
- R7: `grant_line` equals `(winner rank + rot_base) mod 8`. It and `grant_valid` follow the inputs in the same cycle, with no clock.
- R8: `int_out` is 0 during reset. After reset it equals the value `grant_valid` had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vec | input | 8 | Request lines |
| mask_vec | input | 8 | Mask bits; 1 masks the line |
| isr_vec | input | 8 | In-service bits |
| rot_base | input | 3 | Rotation base; this line has the best rank |
| spec_mask_en | input | 1 | Special mask mode |
| spec_nest_en | input | 1 | Special nesting mode |
| is_master | input | 1 | Master role |
| grant_valid | output | 1 | A request outranks the current service level |
| grant_line | output | 3 | Winning line index |
| int_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the inputs are synchronous and hold steady across each rising edge. The bench meets this by changing all inputs only after a falling edge.

The blocking and forwarding properties also assume that the mode flags match the case they describe. For example, the in-service-at-base blocking check applies only while both special modes are off. The stimulus covers every rotation base with random vectors, including cases with both modes on, so that these guarded properties are exercised as well as violated-looking cases that they rightly exclude.

// File: rtl/prio_pkg.sv
package prio_pkg;
    localparam int DEF_LINES   = 8;
    localparam int DEF_CASCADE = 2;
endpackage

// File: rtl/prio_rank_find.sv
// Rotate the vector so the base line lands at bit 0, then find the lowest set bit.
module prio_rank_find #(
    parameter int N = prio_pkg::DEF_LINES,
    localparam int IDX_W  = $clog2(N),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic [N-1:0]      vec,
    input  logic [IDX_W-1:0]  base,
    output logic [RANK_W-1:0] rank
);
    logic [2*N-1:0] dbl;
    logic [2*N-1:0] shifted;
    logic [N-1:0]   rot;

    assign dbl     = {vec, vec};
    assign shifted = dbl >> base;
    assign rot     = shifted[N-1:0];

    always_comb begin
        rank = RANK_W'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                rank = RANK_W'(k);
            end
        end
    end
endmodule

// File: rtl/prio_service_mask.sv
// Adjust the in-service set for special mask and special nesting modes.
module prio_service_mask #(
    parameter int N       = prio_pkg::DEF_LINES,
    parameter int CASCADE = prio_pkg::DEF_CASCADE
) (
    input  logic [N-1:0] isr_vec,
    input  logic [N-1:0] mask_vec,
    input  logic         spec_mask_en,
    input  logic         spec_nest_en,
    input  logic         is_master,
    output logic [N-1:0] svc_vec
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic keep;
        if (i == CASCADE) begin : g_casc
            assign keep = !(spec_mask_en && mask_vec[i]) && !(spec_nest_en && is_master);
        end else begin : g_plain
            assign keep = !(spec_mask_en && mask_vec[i]);
        end
        assign svc_vec[i] = isr_vec[i] && keep;
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
    parameter int NUM_LINES = prio_pkg::DEF_LINES,
    parameter int CASCADE   = prio_pkg::DEF_CASCADE,
    localparam int IDX_W  = $clog2(NUM_LINES),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_vec,
    input  logic [NUM_LINES-1:0] mask_vec,
    input  logic [NUM_LINES-1:0] isr_vec,
    input  logic [IDX_W-1:0]     rot_base,
    input  logic                 spec_mask_en,
    input  logic                 spec_nest_en,
    input  logic                 is_master,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_line,
    output logic                 int_out
);
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] svc_vec;
    logic [RANK_W-1:0]    pend_rank;
    logic [RANK_W-1:0]    svc_rank;

    assign pend_vec = req_vec & ~mask_vec;

    prio_service_mask #(.N(NUM_LINES), .CASCADE(CASCADE)) u_svc (
        .isr_vec      (isr_vec),
        .mask_vec     (mask_vec),
        .spec_mask_en (spec_mask_en),
        .spec_nest_en (spec_nest_en),
        .is_master    (is_master),
        .svc_vec      (svc_vec)
    );

    prio_rank_find #(.N(NUM_LINES)) u_pend_rank (
        .vec  (pend_vec),
        .base (rot_base),
        .rank (pend_rank)
    );

    prio_rank_find #(.N(NUM_LINES)) u_svc_rank (
        .vec  (svc_vec),
        .base (rot_base),
        .rank (svc_rank)
    );

    assign grant_valid = pend_rank < svc_rank;
    assign grant_line  = pend_rank[IDX_W-1:0] + rot_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_out <= 1'b0;
        end else begin
            int_out <= grant_valid;
        end
    end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] req_vec,
    input logic [NUM_LINES-1:0] mask_vec,
    input logic [NUM_LINES-1:0] isr_vec,
    input logic [IDX_W-1:0]     rot_base,
    input logic                 spec_mask_en,
    input logic                 spec_nest_en,
    input logic                 grant_valid,
    input logic [IDX_W-1:0]     grant_line,
    input logic                 int_out
);
    p_winner_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (req_vec[grant_line] && !mask_vec[grant_line]));

    p_empty_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_vec & ~mask_vec) == '0) |-> !grant_valid);

    p_base_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec[rot_base] && !mask_vec[rot_base] && isr_vec == '0)
        |-> (grant_valid && grant_line == rot_base));

    p_base_service_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_mask_en && !spec_nest_en && isr_vec[rot_base]) |-> !grant_valid);

    p_int_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int_out == $past(grant_valid)));
endmodule

bind prio_resolver prio_resolver_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_vec      (req_vec),
    .mask_vec     (mask_vec),
    .isr_vec      (isr_vec),
    .rot_base     (rot_base),
    .spec_mask_en (spec_mask_en),
    .spec_nest_en (spec_nest_en),
    .grant_valid  (grant_valid),
    .grant_line   (grant_line),
    .int_out      (int_out)
);

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0;
    logic [2:0] rot_base = '0;
    logic       spec_mask_en = 1'b0, spec_nest_en = 1'b0, is_master = 1'b0;
    logic       grant_valid, int_out;
    logic [2:0] grant_line;

    int  total = 0;
    int  bad = 0;
    bit  prev_exp = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
        .isr_vec(isr_vec), .rot_base(rot_base), .spec_mask_en(spec_mask_en),
        .spec_nest_en(spec_nest_en), .is_master(is_master),
        .grant_valid(grant_valid), .grant_line(grant_line), .int_out(int_out)
    );

    function automatic int rank_of(logic [7:0] v, int b);
        for (int k = 0; k < 8; k++) begin
            if (v[(k + b) % 8]) return k;
        end
        return 8;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one input set after a falling edge. First check the flop against
    // the previous expectation, then check the combinational outputs.
    task automatic apply(string tag, logic [7:0] rq, logic [7:0] mk, logic [7:0] is,
                         logic [2:0] b, bit sm, bit sn, bit ms);
        logic [7:0] pend, svc;
        int pr, sr;
        bit ev;
        @(negedge clk);
        check("R8 int_out", int_out, prev_exp);
        req_vec = rq; mask_vec = mk; isr_vec = is; rot_base = b;
        spec_mask_en = sm; spec_nest_en = sn; is_master = ms;
        pend = rq & ~mk;
        svc = is;
        if (sm) svc = svc & ~mk;
        if (sn && ms) svc[2] = 1'b0;
        pr = rank_of(pend, b);
        sr = rank_of(svc, b);
        ev = (pr < sr);
        #1;
        check({tag, " valid"}, grant_valid, ev);
        if (ev) check({tag, " R7 line"}, grant_line, (pr + b) % 8);
        prev_exp = ev;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        check("R8 reset int_out", int_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        prev_exp = 1'b0;
        apply("R3 empty", 8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
        apply("R1 masked", 8'h10, 8'h10, 8'h00, 3'd0, 0, 0, 0);
        apply("R2 base5 picks 6", 8'h41, 8'h00, 8'h00, 3'd5, 0, 0, 0);
        apply("R2 wrap", 8'h09, 8'h00, 8'h00, 3'd4, 0, 0, 0);
        apply("R4 equal blocks", 8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0);
        apply("R4 better wins", 8'h02, 8'h00, 8'h08, 3'd0, 0, 0, 0);
        apply("R5 off blocks", 8'h20, 8'h01, 8'h01, 3'd0, 0, 0, 0);
        apply("R5 on passes", 8'h20, 8'h01, 8'h01, 3'd0, 1, 0, 0);
        apply("R6 master ignores", 8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1);
        apply("R6 slave blocks", 8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 0);
        apply("R6 no nest blocks", 8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 1);
        apply("R8 drop", 8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
        for (int b = 0; b < 8; b++) begin
            for (int n = 0; n < 300; n++) begin
                apply("R2 R4 random", 8'($urandom), 8'($urandom) & 8'($urandom),
                      8'($urandom) & 8'($urandom) & 8'($urandom), 3'(b),
                      1'($urandom), 1'($urandom), 1'($urandom));
            end
        end
        apply("R8 tail", 8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule